// File: doc/BRIEF.md
# Instruction-Sequence Self-Test Controller

This controller tests a small accumulator datapath using ordinary instructions instead of scan chains. The datapath has an accumulator A, an operand register R and an output register OUT. The controller issues one instruction per cycle, together with its IN data. Each test step does four things in order: load R from IN, load A from IN, run the operation under test, then copy A to OUT. One idle slot follows. In that slot the controller compares the datapath's OUT against a value it computes itself.

There are two modes.

- **Adder scan** runs the add operation once for every pair of A and R values. With the default width of 4 bits this is 256 steps.
- **Decoder conformity** runs each of the ten instructions once. It uses fixed A, R and IN values chosen so that the input values and the operation results all differ. A wrong decode therefore changes OUT.

A one-cycle `start` begins a run in the selected mode. The first mismatch in a run is latched as `fail`, together with the mode, the step index and the instruction under test. The run always finishes and then pulses `done`.

Top module: `istest_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `instr_vld` are low, and `fail_mode`, `fail_step` and `fail_instr` are zero.
- R2: `start` while idle begins a run with `mode` sampled at that edge (0 = adder scan, 1 = decoder conformity). While `busy` is high, `start` and `mode` have no effect on the instruction stream.
- R3: In adder scan, step s (s = 0 to 2^(2W)−1, in increasing order) issues codes 4, 0, 6, 3 with IN = s[W−1:0], s[2W−1:W], 0, 0. An idle slot with `instr_vld` low follows.
- R4: In decoder conformity, step k (k = 0 to 9) issues codes 4, 0, k, 3 with IN = CONF_R, CONF_A, CONF_IN, 0. An idle slot follows.
- R5: The opcodes are:
  - 0 and 5: A←IN
  - 1: R←A
  - 2: OUT←R
  - 3: OUT←A
  - 4: R←IN
  - 6: A←A+R (mod 2^W)
  - 7: A←A|R
  - 8: A←A&R
  - 9: A←~A
  
  `instr_vld` is only high with a code from 0 to 9.
- R6: In each idle slot, `dp_out` is compared with the A value expected after the step's third instruction, using the R5 definitions. `fail` can only rise on the edge that ends an idle slot.
- R7: The first mismatch of a run sets `fail` and captures `fail_mode`, `fail_step` and `fail_instr` (the code of the third instruction of the step). Later mismatches leave these unchanged. An accepted `start` clears them.
- R8: `done` is high for exactly one cycle: the cycle after the last step's idle slot. In that cycle `busy` and `instr_vld` are low and the fail fields are final.
- R9: The default conformity data (A=5, R=3, IN=12) gives seven distinct values: 5, 3, 12, 8, 7, 1 and 10. As a result, a decoder that runs OR as AND is reported at step 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| mode | input | 1 | 0 = adder scan, 1 = decoder conformity |
| instr_vld | output | 1 | An instruction is issued this cycle |
| instr | output | 4 | Instruction code to the datapath |
| in_data | output | W | IN data to the datapath |
| dp_out | input | W | OUT register of the datapath |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | A mismatch was seen in this run |
| fail_mode | output | 1 | Mode of the first mismatch |
| fail_step | output | 2W | Step index of the first mismatch |
| fail_instr | output | 4 | Instruction under test at the first mismatch |

## Verification
The properties assume a datapath whose OUT register is written on the same edge that samples the output instruction. Under that assumption, `dp_out` is settled throughout the idle slot. The properties also rely on the environment releasing reset before any `start`.

The stimulus drives `start` and `mode` only on falling edges. It deliberately pulses `start` with the opposite mode in the middle of a run.

The bench's datapath model registers OUT in this way and can inject single or multiple operation faults. This keeps every mismatch inside the timing window that the fail-capture properties describe.

// File: rtl/stc_pkg.sv
// Shared opcodes, mode encoding and step layout for the self-test controller.
// Assumes a datapath that executes one instruction per valid cycle.
package stc_pkg;
    typedef enum logic [3:0] {
        OP_LDA   = 4'd0,
        OP_MOVRA = 4'd1,
        OP_OUTR  = 4'd2,
        OP_OUTA  = 4'd3,
        OP_LDR   = 4'd4,
        OP_LDA2  = 4'd5,
        OP_ADD   = 4'd6,
        OP_OR    = 4'd7,
        OP_AND   = 4'd8,
        OP_NOT   = 4'd9
    } op_e;

    localparam int NUM_OPS  = 10;
    localparam int SLOTS    = 5;
    localparam int SLOT_W   = 3;
    localparam logic MODE_SCAN = 1'b0;
    localparam logic MODE_CONF = 1'b1;
endpackage

// File: rtl/stc_seq.sv
// Step/slot sequencer: accepts start when idle, walks steps of five slots
// (four instructions plus one compare slot), and pulses done at the end.
// Assumes SW >= 4 so that the conformity step count fits.
module stc_seq
    import stc_pkg::*;
#(
    parameter int W  = 4,
    parameter int SW = 2 * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    output logic              busy,
    output logic              mode_q,
    output logic [SW-1:0]     step,
    output logic [SLOT_W-1:0] slot,
    output logic              launch,
    output logic              cmp_en,
    output logic              done
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [SW-1:0]     LAST_CONF = SW'(NUM_OPS - 1);
    localparam logic [SW-1:0]     LAST_SCAN = {SW{1'b1}};

    logic [SW-1:0] last_step;

    // Final step index for the latched mode.
    always_comb last_step = (mode_q == MODE_CONF) ? LAST_CONF : LAST_SCAN;

    // Start accepted only while idle.
    assign launch = start && !busy;
    // Compare happens in the idle slot of every step.
    assign cmp_en = busy && (slot == LAST_SLOT);

    // Run state, step and slot counters, end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            mode_q <= MODE_SCAN;
            step   <= '0;
            slot   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                busy   <= 1'b1;
                mode_q <= mode;
                step   <= '0;
                slot   <= '0;
            end else if (busy) begin
                if (slot == LAST_SLOT) begin
                    slot <= '0;
                    if (step == last_step) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        step <= step + 1'b1;
                    end
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/stc_stim.sv
// Stimulus generator: maps mode, step and slot onto the instruction code and
// IN data, and exposes the operand set and the instruction under test.
// Purely combinational; relies on the sequencer holding step for five slots.
module stc_stim
    import stc_pkg::*;
#(
    parameter int             W       = 4,
    parameter int             SW      = 2 * W,
    parameter logic [W-1:0]   CONF_A  = W'(5),
    parameter logic [W-1:0]   CONF_R  = W'(3),
    parameter logic [W-1:0]   CONF_IN = W'(12)
) (
    input  logic              busy,
    input  logic              mode_q,
    input  logic [SW-1:0]     step,
    input  logic [SLOT_W-1:0] slot,
    output logic              instr_vld,
    output logic [3:0]        instr,
    output logic [W-1:0]      in_data,
    output op_e               op_ut,
    output logic [W-1:0]      opnd_a,
    output logic [W-1:0]      opnd_r,
    output logic [W-1:0]      opnd_in
);
    // Operand set and instruction under test for the current step.
    always_comb begin
        if (mode_q == MODE_CONF) begin
            opnd_a  = CONF_A;
            opnd_r  = CONF_R;
            opnd_in = CONF_IN;
            op_ut   = op_e'(step[3:0]);
        end else begin
            opnd_a  = step[SW-1:W];
            opnd_r  = step[W-1:0];
            opnd_in = '0;
            op_ut   = OP_ADD;
        end
    end

    // Slot decode into the four-instruction sequence.
    always_comb begin
        instr_vld = 1'b0;
        instr     = 4'd0;
        in_data   = '0;
        if (busy) begin
            case (slot)
                3'd0: begin instr_vld = 1'b1; instr = OP_LDR;  in_data = opnd_r;  end
                3'd1: begin instr_vld = 1'b1; instr = OP_LDA;  in_data = opnd_a;  end
                3'd2: begin instr_vld = 1'b1; instr = op_ut;   in_data = opnd_in; end
                3'd3: begin instr_vld = 1'b1; instr = OP_OUTA; in_data = '0;      end
                default: begin instr_vld = 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/stc_expect.sv
// Reference model of the ten operations: gives the accumulator value that
// follows the instruction under test, given A, R and IN before it.
module stc_expect
    import stc_pkg::*;
#(
    parameter int W = 4
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] r,
    input  logic [W-1:0] c,
    output logic [W-1:0] exp_a
);
    // Accumulator result of one operation.
    always_comb begin
        case (op)
            OP_LDA, OP_LDA2: exp_a = c;
            OP_ADD:          exp_a = a + r;
            OP_OR:           exp_a = a | r;
            OP_AND:          exp_a = a & r;
            OP_NOT:          exp_a = ~a;
            default:         exp_a = a;
        endcase
    end
endmodule

// File: rtl/stc_check.sv
// Comparator and first-fail capture. Compares OUT in the idle slot and keeps
// the first mismatch's mode, step and instruction until the next launch.
module stc_check
    import stc_pkg::*;
#(
    parameter int W  = 4,
    parameter int SW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          cmp_en,
    input  logic [W-1:0]  exp_a,
    input  logic [W-1:0]  dp_out,
    input  logic          mode_q,
    input  logic [SW-1:0] step,
    input  op_e           op_ut,
    output logic          fail,
    output logic          fail_mode,
    output logic [SW-1:0] fail_step,
    output logic [3:0]    fail_instr
);
    logic mismatch;

    // Mismatch in the compare slot.
    always_comb mismatch = cmp_en && (dp_out != exp_a);

    // First-fail latch, cleared on launch.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            fail       <= 1'b0;
            fail_mode  <= 1'b0;
            fail_step  <= '0;
            fail_instr <= 4'd0;
        end else if (mismatch && !fail) begin
            fail       <= 1'b1;
            fail_mode  <= mode_q;
            fail_step  <= step;
            fail_instr <= op_ut;
        end
    end
endmodule

// File: rtl/istest_ctrl.sv
// Top of the instruction-sequence self-test controller. Drives a registered
// accumulator datapath (one instruction per cycle, OUT written on the edge
// that samples the output instruction) and checks OUT in a compare slot.
module istest_ctrl
    import stc_pkg::*;
#(
    parameter int           W       = 4,
    parameter logic [W-1:0] CONF_A  = W'(5),
    parameter logic [W-1:0] CONF_R  = W'(3),
    parameter logic [W-1:0] CONF_IN = W'(12),
    localparam int          SW      = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    output logic          instr_vld,
    output logic [3:0]    instr,
    output logic [W-1:0]  in_data,
    input  logic [W-1:0]  dp_out,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic          fail_mode,
    output logic [SW-1:0] fail_step,
    output logic [3:0]    fail_instr
);
    logic              mode_q;
    logic [SW-1:0]     step;
    logic [SLOT_W-1:0] slot;
    logic              launch;
    logic              cmp_en;
    op_e               op_ut;
    logic [W-1:0]      opnd_a;
    logic [W-1:0]      opnd_r;
    logic [W-1:0]      opnd_in;
    logic [W-1:0]      exp_a;

    stc_seq #(.W(W), .SW(SW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .busy(busy), .mode_q(mode_q), .step(step), .slot(slot),
        .launch(launch), .cmp_en(cmp_en), .done(done)
    );

    stc_stim #(.W(W), .SW(SW), .CONF_A(CONF_A), .CONF_R(CONF_R),
               .CONF_IN(CONF_IN)) u_stim (
        .busy(busy), .mode_q(mode_q), .step(step), .slot(slot),
        .instr_vld(instr_vld), .instr(instr), .in_data(in_data),
        .op_ut(op_ut), .opnd_a(opnd_a), .opnd_r(opnd_r), .opnd_in(opnd_in)
    );

    stc_expect #(.W(W)) u_exp (
        .op(op_ut), .a(opnd_a), .r(opnd_r), .c(opnd_in), .exp_a(exp_a)
    );

    stc_check #(.W(W), .SW(SW)) u_chk_logic (
        .clk(clk), .rst_n(rst_n), .launch(launch), .cmp_en(cmp_en),
        .exp_a(exp_a), .dp_out(dp_out), .mode_q(mode_q), .step(step),
        .op_ut(op_ut), .fail(fail), .fail_mode(fail_mode),
        .fail_step(fail_step), .fail_instr(fail_instr)
    );
endmodule

// File: rtl/istest_ctrl_chk.sv
// Property checker for istest_ctrl, attached by bind. Observes ports only.
module istest_ctrl_chk #(
    parameter int W  = 4,
    parameter int SW = 2 * W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic          instr_vld,
    input logic [3:0]    instr,
    input logic [SW-1:0] fail_step
);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !instr_vld));

    // R5
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_vld |-> (instr < 4'd10));

    // R2
    vld_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_vld |-> busy);

    // R7
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(start && !busy)) |=> (fail && $stable(fail_step)));

    // R6
    fail_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> ($past(busy) && !$past(instr_vld)));
endmodule

bind istest_ctrl istest_ctrl_chk #(.W(W), .SW(2 * W)) u_prop (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .instr_vld(instr_vld), .instr(instr), .fail_step(fail_step)
);

// File: tb/sim_istest_ctrl.sv
// Bench: behavioural datapath with fault knobs, per-cycle expected stream
// held in queues and compared on every falling edge.
module sim_istest_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 4;
    localparam int SW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic          instr_vld;
    logic [3:0]    instr;
    logic [W-1:0]  in_data;
    logic [W-1:0]  dp_out;
    logic          busy, done, fail, fail_mode;
    logic [SW-1:0] fail_step;
    logic [3:0]    fail_instr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int fault = 0;   // bit0: adder 15+1, bit1: OR acts as AND, bit2: NOT is a no-op

    logic [W-1:0] reg_a = '0, reg_r = '0, reg_o = '0;

    istest_ctrl #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .instr_vld(instr_vld), .instr(instr), .in_data(in_data),
        .dp_out(dp_out), .busy(busy), .done(done), .fail(fail),
        .fail_mode(fail_mode), .fail_step(fail_step), .fail_instr(fail_instr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign dp_out = reg_o;

    // Datapath under test, with optional injected faults.
    always @(posedge clk) begin
        if (instr_vld) begin
            case (instr)
                4'd0, 4'd5: reg_a <= in_data;
                4'd1: reg_r <= reg_a;
                4'd2: reg_o <= reg_r;
                4'd3: reg_o <= reg_a;
                4'd4: reg_r <= in_data;
                4'd6: reg_a <= (fault[0] && reg_a == 4'hF && reg_r == 4'h1)
                               ? 4'h1 : reg_a + reg_r;
                4'd7: reg_a <= fault[1] ? (reg_a & reg_r) : (reg_a | reg_r);
                4'd8: reg_a <= reg_a & reg_r;
                4'd9: reg_a <= fault[2] ? reg_a : ~reg_a;
                default: ;
            endcase
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected < 50000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // One full run; poke_at is the stream index where a stray start is driven.
    task automatic do_run(input logic m, input int poke_at, input logic e_fail,
                          input int e_step, input int e_instr);
        bit vq[$]; int cq[$]; int iq[$];
        int nsteps = m ? 10 : 256;
        for (int s = 0; s < nsteps; s++) begin
            int a = m ? 5 : (s >> 4);
            int r = m ? 3 : (s & 15);
            int c = m ? 12 : 0;
            int op = m ? s : 6;
            vq.push_back(1); cq.push_back(4);  iq.push_back(r);
            vq.push_back(1); cq.push_back(0);  iq.push_back(a);
            vq.push_back(1); cq.push_back(op); iq.push_back(c);
            vq.push_back(1); cq.push_back(3);  iq.push_back(0);
            vq.push_back(0); cq.push_back(0);  iq.push_back(0);
        end
        @(negedge clk); start = 1'b1; mode = m;
        @(negedge clk); start = 1'b0; mode = ~m;   // R2: mode change ignored
        for (int i = 0; i < vq.size(); i++) begin
            if (m) begin
                chk(instr_vld == vq[i], "R4 vld", instr_vld, vq[i]);
                if (vq[i]) begin
                    chk(instr == cq[i], "R4 code", instr, cq[i]);
                    chk(in_data == iq[i], "R4 in", in_data, iq[i]);
                end
            end else begin
                chk(instr_vld == vq[i] && (!vq[i] || (instr == cq[i] && in_data == iq[i])),
                    "R3 stream", {instr_vld, instr, in_data}, {vq[i], 4'(cq[i]), 4'(iq[i])});
            end
            chk(!done && busy, "R8 busy", {done, busy}, 1);
            start = (i == poke_at);                   // R2: start while busy
            @(negedge clk);
        end
        start = 1'b0;
        chk(done && !busy && !instr_vld, "R8 done", {done, busy, instr_vld}, 4);
        chk(fail == e_fail, "R7 fail", fail, e_fail);
        if (e_fail) begin
            chk(fail_step == e_step, "R7 step", fail_step, e_step);
            chk(fail_instr == e_instr, "R7 instr", fail_instr, e_instr);
            chk(fail_mode == m, "R7 mode", fail_mode, m);
        end
        @(negedge clk);
        chk(!done, "R8 pulse", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !fail && !instr_vld, "R1 flags",
            {busy, done, fail, instr_vld}, 0);
        chk(fail_step == 0 && fail_instr == 0 && !fail_mode, "R1 fields",
            fail_step, 0);
        // R3 clean scan with stray start mid-run (R2)
        fault = 0; do_run(1'b0, 300, 1'b0, 0, 0);
        // R3 R6 adder fault at A=15,R=1 -> step 241
        fault = 1; do_run(1'b0, -1, 1'b1, 241, 6);
        // R4 clean conformity, stray start at end
        fault = 0; do_run(1'b1, 49, 1'b0, 0, 0);
        // R9 OR decoded as AND -> step 7
        fault = 2; do_run(1'b1, -1, 1'b1, 7, 7);
        // R5 NOT broken alone -> step 9
        fault = 4; do_run(1'b1, 12, 1'b1, 9, 9);
        // R7 two faults: first one (step 7) kept
        fault = 6; do_run(1'b1, -1, 1'b1, 7, 7);
        // R7 clean run after a failing one clears fail
        fault = 0; do_run(1'b1, -1, 1'b0, 0, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule